// File: doc/BRIEF.md
# Root Port INTx Event Queue and Interrupt Registers

This block collects legacy INTx level changes from four interrupt lanes of a PCIe root port and holds them in a small circular queue. Software reads the oldest pending event through a 32-bit register port and removes it by writing. The block also keeps an interrupt decode register and an interrupt mask register, and it drives one level-sensitive interrupt line towards the host. A link-up status bit and a bridge-enable control bit sit in the same register space.

Every rising or falling edge on an INTx input becomes one queue entry. Each entry records the lane and the new level. When several lanes change in the same cycle, they are queued lowest lane first. The queue keeps one slot unused, so it holds at most FIFO_DEPTH-1 events. An event that arrives when the queue is full is dropped and raises a sticky overflow flag. An MSI pulse input only sets its decode bit.

The register port uses word addresses, which are the byte offsets divided by four. Reads are combinational and have no side effects. A write takes effect at the next clock edge. The input lines are sampled while reset is held, so a line that is already high when reset is released does not produce an event. FIFO_DEPTH must be a power of two and at least 2.

Top module: `rp_intx_regs`

## Requirements
- R1: Only six word addresses are mapped: 0x04E decode, 0x04F mask, 0x051 PHY status, 0x052 port status/control, 0x056 event word one and 0x057 event word two. Reads of any other address return 0, and writes to other addresses, or to 0x051, change nothing.
- R2: Bit 11 of the PHY status register (0x051) equals the `link_up` input. Every other bit of that register reads 0.
- R3: Bit 0 of the port status/control register (0x052) is read/write and drives `bridge_en`. `bridge_en` changes only on a write to 0x052. It is 0 after reset.
- R4: Each edge on `intx_in[l]` queues one event. Lanes that change in the same cycle are queued lowest lane first. Event word one (0x056) shows the oldest event, with bit 31 = 1 (valid), bit 29 = the new level, bits 28:27 = the lane, and all other bits 0. Event word two (0x057) always reads 0.
- R5: The queue holds at most FIFO_DEPTH-1 events. An event that arrives when the queue is full is discarded and sets bit 19 of 0x052. That bit stays set until 1 is written to bit 19. A new overflow in the same cycle as the clearing write leaves the bit set.
- R6: Bit 18 of 0x052 reads 1 exactly when the queue holds at least one event.
- R7: Event word one reads 0 while the queue is empty. A write to 0x056 or 0x057 removes the oldest event. The same write while the queue is empty has no effect.
- R8: In the decode register (0x04E), bit 16 is set by every queued event and bit 17 is set by an `msi_pulse`. Writing 1 to either bit clears it. A set in the same cycle as the clearing write wins. Bit 16 reads 1 for as long as the queue is non-empty. All other decode bits read 0.
- R9: The mask register (0x04F) is a 32-bit read/write register that resets to 0. `irq_out` is 1 exactly when the decode value AND the mask value is non-zero.
- R10: When a removal and new events fall in the same cycle, the removal is applied first. A full queue that is popped and receives one event in the same cycle therefore stores the event and does not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intx_in | input | 4 | INTx level per lane |
| msi_pulse | input | 1 | One-cycle MSI received indication |
| link_up | input | 1 | PHY link-up status |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Level interrupt to the host |
| bridge_en | output | 1 | Bridge-enable control |

## Verification
Three stimulus patterns exercise the queue, and each shows a different fault:
- A single lane rising catches a wrong bit position in the event word.
- Changing all four lanes at once, with mixed directions, catches a wrong lane order or a lost simultaneous event.
- Toggling one lane many times overfills the queue, which pins down the capacity, the drop and the sticky flag.

A pop in the same cycle as a push into a full queue separates "pop first" from "push first". Clearing the decode bit while events are still queued, and again after they have drained, shows the forced INTx bit apart from the stored one. An MSI pulse that lands on the clearing write checks the set-beats-clear rule.

// File: rtl/rp_intx_pkg.sv
package rp_intx_pkg;

    localparam int NUM_LANES = 4;
    localparam int LANE_W    = 2;
    localparam int DATA_W    = 32;

    // register word addresses (byte offset / 4)
    localparam int unsigned ADR_DECODE = 32'h04E;
    localparam int unsigned ADR_MASK   = 32'h04F;
    localparam int unsigned ADR_PHY    = 32'h051;
    localparam int unsigned ADR_PORT   = 32'h052;
    localparam int unsigned ADR_EVT1   = 32'h056;
    localparam int unsigned ADR_EVT2   = 32'h057;

    // bit positions
    localparam int B_INTX   = 16;
    localparam int B_MSI    = 17;
    localparam int B_LINK   = 11;
    localparam int B_BREN   = 0;
    localparam int B_NEMPTY = 18;
    localparam int B_OVF    = 19;
    localparam int B_LANE   = 27;
    localparam int B_LEVEL  = 29;
    localparam int B_VALID  = 31;

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic              level;
    } intx_evt_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_DECODE, SEL_MASK, SEL_PHY, SEL_PORT, SEL_EVT1, SEL_EVT2
    } reg_sel_e;

    function automatic reg_sel_e addr_sel(input int unsigned a);
        case (a)
            ADR_DECODE: return SEL_DECODE;
            ADR_MASK:   return SEL_MASK;
            ADR_PHY:    return SEL_PHY;
            ADR_PORT:   return SEL_PORT;
            ADR_EVT1:   return SEL_EVT1;
            ADR_EVT2:   return SEL_EVT2;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] evt_word(input intx_evt_t e);
        logic [DATA_W-1:0] w;
        w                        = '0;
        w[B_VALID]               = 1'b1;
        w[B_LEVEL]               = e.level;
        w[B_LANE +: LANE_W]      = e.lane;
        return w;
    endfunction

endpackage

// File: rtl/rp_intx_edge.sv
module rp_intx_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    output logic [N-1:0] changed
);
    logic [N-1:0] prev_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            // tracks the line during reset too, so no event appears at release
            always_ff @(posedge clk) begin
                prev_q[g] <= lines[g];
            end
            assign changed[g] = !rst && (lines[g] != prev_q[g]);
        end
    endgenerate
endmodule

// File: rtl/rp_intx_fifo.sv
module rp_intx_fifo
    import rp_intx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int N     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] push_vec,
    input  logic [N-1:0] push_lvl,
    input  logic         pop,
    output intx_evt_t    head,
    output logic         nonempty,
    output logic         accepted,
    output logic         dropped
);
    localparam int PTR_W = $clog2(DEPTH);

    intx_evt_t        mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_after, wr_next, walk;
    logic [PTR_W-1:0] slot [N];
    logic [N-1:0]     take;
    logic             pop_ok;

    always_comb begin
        pop_ok   = pop && (wr_ptr != rd_ptr);
        rd_after = rd_ptr + PTR_W'(pop_ok);
        walk     = wr_ptr;
        dropped  = 1'b0;
        for (int l = 0; l < N; l++) begin
            slot[l] = walk;
            take[l] = 1'b0;
            if (push_vec[l]) begin
                if (PTR_W'(walk + 1'b1) != rd_after) begin
                    take[l] = 1'b1;
                    walk    = PTR_W'(walk + 1'b1);
                end else begin
                    dropped = 1'b1;
                end
            end
        end
        wr_next = walk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            rd_ptr <= rd_after;
            wr_ptr <= wr_next;
        end
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < N; l++) begin
            if (take[l]) begin
                mem[slot[l]] <= '{lane: LANE_W'(l), level: push_lvl[l]};
            end
        end
    end

    assign head     = mem[rd_ptr];
    assign nonempty = (wr_ptr != rd_ptr);
    assign accepted = |take;
endmodule

// File: rtl/rp_intx_regs.sv
module rp_intx_regs
    import rp_intx_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LANES-1:0] intx_in,
    input  logic                 msi_pulse,
    input  logic                 link_up,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_out,
    output logic                 bridge_en
);
    reg_sel_e            sel;
    logic [NUM_LANES-1:0] lane_chg;
    intx_evt_t           head;
    logic                fifo_nonempty, fifo_acc, fifo_drop, pop_req;
    logic                wr_decode, wr_mask, wr_port;
    logic                dec_intx_q, dec_msi_q, bren_q, ovf_q;
    logic [DATA_W-1:0]   mask_q, decode_word, port_word, phy_word;

    assign sel       = addr_sel(32'(reg_addr));
    assign wr_decode = reg_wr && (sel == SEL_DECODE);
    assign wr_mask   = reg_wr && (sel == SEL_MASK);
    assign wr_port   = reg_wr && (sel == SEL_PORT);
    assign pop_req   = reg_wr && ((sel == SEL_EVT1) || (sel == SEL_EVT2));

    rp_intx_edge #(.N(NUM_LANES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .lines   (intx_in),
        .changed (lane_chg)
    );

    rp_intx_fifo #(.DEPTH(FIFO_DEPTH), .N(NUM_LANES)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push_vec (lane_chg),
        .push_lvl (intx_in),
        .pop      (pop_req),
        .head     (head),
        .nonempty (fifo_nonempty),
        .accepted (fifo_acc),
        .dropped  (fifo_drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_intx_q <= 1'b0;
            dec_msi_q  <= 1'b0;
            mask_q     <= '0;
            bren_q     <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            dec_intx_q <= (dec_intx_q && !(wr_decode && reg_wdata[B_INTX])) || fifo_acc;
            dec_msi_q  <= (dec_msi_q && !(wr_decode && reg_wdata[B_MSI])) || msi_pulse;
            ovf_q      <= (ovf_q && !(wr_port && reg_wdata[B_OVF])) || fifo_drop;
            if (wr_mask) mask_q <= reg_wdata;
            if (wr_port) bren_q <= reg_wdata[B_BREN];
        end
    end

    always_comb begin
        decode_word           = '0;
        decode_word[B_INTX]   = dec_intx_q || fifo_nonempty;
        decode_word[B_MSI]    = dec_msi_q;
        port_word             = '0;
        port_word[B_BREN]     = bren_q;
        port_word[B_NEMPTY]   = fifo_nonempty;
        port_word[B_OVF]      = ovf_q;
        phy_word              = '0;
        phy_word[B_LINK]      = link_up;
    end

    always_comb begin
        case (sel)
            SEL_DECODE: reg_rdata = decode_word;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_PHY:    reg_rdata = phy_word;
            SEL_PORT:   reg_rdata = port_word;
            SEL_EVT1:   reg_rdata = fifo_nonempty ? evt_word(head) : '0;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_out   = |(decode_word & mask_q);
    assign bridge_en = bren_q;
endmodule

// File: rtl/rp_intx_regs_chk.sv
module rp_intx_regs_chk
    import rp_intx_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_out,
    input logic              bridge_en,
    input logic              fifo_nonempty,
    input logic              ovf_flag,
    input logic              mask_intx
);
    logic at_port, at_evt;
    assign at_port = (reg_addr == ADDR_W'(ADR_PORT));
    assign at_evt  = (reg_addr == ADDR_W'(ADR_EVT1)) || (reg_addr == ADDR_W'(ADR_EVT2));

    a_r3_bridge_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && at_port) |=> $stable(bridge_en));

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(reg_wr && at_port && reg_wdata[B_OVF])) |=> ovf_flag);

    a_r6_nempty_bit: assert property (@(posedge clk) disable iff (rst)
        at_port |-> (reg_rdata[B_NEMPTY] == fifo_nonempty));

    a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (at_evt && !fifo_nonempty) |-> (reg_rdata == '0));

    a_r8_intx_held_irq: assert property (@(posedge clk) disable iff (rst)
        (fifo_nonempty && mask_intx) |-> irq_out);
endmodule

bind rp_intx_regs rp_intx_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq_out       (irq_out),
    .bridge_en     (bridge_en),
    .fifo_nonempty (fifo_nonempty),
    .ovf_flag      (ovf_q),
    .mask_intx     (mask_q[16])
);

// File: tb/rp_intx_regs_bench.sv
module rp_intx_regs_bench;
    localparam int DEPTH = 16;
    localparam int A_DEC = 'h04E, A_MASK = 'h04F, A_PHY = 'h051, A_PORT = 'h052,
                   A_EV1 = 'h056, A_EV2 = 'h057, A_NONE = 'h050;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  intx_in = '0;
    logic        msi_pulse = 1'b0;
    logic        link_up = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out, bridge_en;

    int checks = 0;
    int errors = 0;

    // reference model state
    int   q[$];
    logic [3:0] m_prev = '0;
    logic m_dint = 0, m_dmsi = 0, m_bren = 0, m_ovf = 0;
    logic [31:0] m_mask = '0;
    logic [3:0] cur = '0;

    rp_intx_regs #(.ADDR_W(10), .FIFO_DEPTH(DEPTH)) u_rp_intx_regs (
        .clk(clk), .rst(rst), .intx_in(intx_in), .msi_pulse(msi_pulse),
        .link_up(link_up), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
        .bridge_en(bridge_en));

    always #10 clk = ~clk;

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] v;
        v = '0;
        case (a)
            A_DEC:  begin v[16] = m_dint || (q.size() > 0); v[17] = m_dmsi; end
            A_MASK: v = m_mask;
            A_PHY:  v[11] = link_up;
            A_PORT: begin v[0] = m_bren; v[18] = (q.size() > 0); v[19] = m_ovf; end
            A_EV1:  if (q.size() > 0)
                        v = 32'h8000_0000 | (32'(q[0] >> 2) << 29) | (32'(q[0] & 3) << 27);
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic [3:0] lines, input logic msi, input logic wr,
                              input int a, input logic [31:0] wd);
        bit acc, drop;
        acc = 0; drop = 0;
        if (wr && (a == A_EV1 || a == A_EV2) && q.size() > 0) void'(q.pop_front());
        for (int l = 0; l < 4; l++) begin
            if (lines[l] != m_prev[l]) begin
                if (q.size() < DEPTH - 1) begin q.push_back(l | (int'(lines[l]) << 2)); acc = 1; end
                else drop = 1;
            end
        end
        m_prev = lines;
        if (wr && a == A_DEC) begin
            if (wd[16]) m_dint = 0;
            if (wd[17]) m_dmsi = 0;
        end
        if (acc) m_dint = 1;
        if (msi) m_dmsi = 1;
        if (wr && a == A_MASK) m_mask = wd;
        if (wr && a == A_PORT) begin
            m_bren = wd[0];
            if (wd[19]) m_ovf = 0;
        end
        if (drop) m_ovf = 1;
    endtask

    // called at a falling edge; applies inputs across one rising edge
    task automatic step(input logic [3:0] lines, input logic msi, input logic wr,
                        input int a, input logic [31:0] wd);
        logic exp_irq;
        intx_in = lines; msi_pulse = msi; reg_wr = wr;
        reg_addr = 10'(a); reg_wdata = wd;
        @(posedge clk);
        model_edge(lines, msi, wr, a, wd);
        @(negedge clk);
        reg_wr = 0; msi_pulse = 0;
        exp_irq = |(m_read(A_DEC) & m_mask);
        check(irq_out === exp_irq, "R9 irq_out", 32'(irq_out), 32'(exp_irq));
        check(bridge_en === m_bren, "R3 bridge_en", 32'(bridge_en), 32'(m_bren));
    endtask

    task automatic idle();
        step(cur, 0, 0, A_NONE, 0);
    endtask

    task automatic rd(input int a, input string tag);
        reg_addr = 10'(a);
        #1;
        check(reg_rdata === m_read(a), tag, reg_rdata, m_read(a));
    endtask

    task automatic chk_all(input string tag);
        rd(A_DEC, {tag, " decode"});
        rd(A_MASK, {tag, " mask"});
        rd(A_PHY, {tag, " phy"});
        rd(A_PORT, {tag, " port"});
        rd(A_EV1, {tag, " evt1"});
        rd(A_EV2, {tag, " evt2"});
        rd(A_NONE, {tag, " unmapped"});
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk_all("R1 reset");
        check(irq_out === 1'b0, "R9 reset irq", 32'(irq_out), 0);

        // R2 link status
        link_up = 1; rd(A_PHY, "R2 link high");
        link_up = 0; rd(A_PHY, "R2 link low");

        // R3 bridge enable
        step(cur, 0, 1, A_PORT, 32'hFFF0_0001 & ~32'h0008_0000);
        chk_all("R3 set");
        idle(); idle();
        step(cur, 0, 1, A_PORT, 32'h0);
        chk_all("R3 clear");

        // R1 unmapped and read-only writes
        step(cur, 0, 1, A_MASK, 32'h1234_5678);
        step(cur, 0, 1, A_NONE, 32'hFFFF_FFFF);
        step(cur, 0, 1, A_PHY, 32'hFFFF_FFFF);
        chk_all("R1 ignored writes");
        step(cur, 0, 1, A_MASK, 32'h0);

        // R4 single rising lane 2
        cur = 4'b0100; step(cur, 0, 0, A_NONE, 0);
        rd(A_EV1, "R4 single lane2");
        check(reg_rdata === 32'hB000_0000, "R4 word layout", reg_rdata, 32'hB000_0000);
        chk_all("R4 single");

        // R7 pop via word two, then pop when empty
        step(cur, 0, 1, A_EV2, 0);
        chk_all("R7 popped");
        step(cur, 0, 1, A_EV1, 0);
        chk_all("R7 pop empty");

        // R4 all four lanes change together, mixed directions
        cur = 4'b1011; step(cur, 0, 0, A_NONE, 0);
        for (int i = 0; i < 4; i++) begin
            chk_all("R4 lane order");
            step(cur, 0, 1, A_EV1, 0);
        end
        chk_all("R4 drained");

        // R5 overflow by repeated toggling
        for (int i = 0; i < 20; i++) begin
            cur[0] = ~cur[0];
            step(cur, 0, 0, A_NONE, 0);
        end
        chk_all("R5 full");
        for (int i = 0; i < DEPTH - 1; i++) begin
            step(cur, 0, 1, A_EV1, 0);
            rd(A_EV1, "R5 drain");
        end
        chk_all("R5 sticky after drain");
        step(cur, 0, 1, A_PORT, 32'h0008_0000);
        chk_all("R5 overflow cleared");

        // R10 pop and push in the same cycle on a full queue
        for (int i = 0; i < DEPTH - 1; i++) begin
            cur[1] = ~cur[1];
            step(cur, 0, 0, A_NONE, 0);
        end
        chk_all("R10 full again");
        cur[3] = ~cur[3];
        step(cur, 0, 1, A_EV1, 0);
        chk_all("R10 pop first");

        // R8 decode held while queue non-empty
        step(cur, 0, 1, A_MASK, 32'h0001_0000);
        step(cur, 0, 1, A_DEC, 32'h0003_0000);
        chk_all("R8 clear while pending");
        for (int i = 0; i < DEPTH - 1; i++) step(cur, 0, 1, A_EV2, 0);
        chk_all("R8 drained sticky");
        step(cur, 0, 1, A_DEC, 32'h0001_0000);
        chk_all("R8 cleared");

        // R8 MSI decode, set wins over clear, R9 mask gating
        step(cur, 1, 0, A_NONE, 0);
        chk_all("R9 msi masked");
        step(cur, 0, 1, A_MASK, 32'h0002_0000);
        chk_all("R9 msi unmasked");
        step(cur, 1, 1, A_DEC, 32'h0002_0000);
        chk_all("R8 set beats clear");
        step(cur, 0, 1, A_DEC, 32'h0002_0000);
        chk_all("R8 msi cleared");

        // R5 overflow set in the same cycle as its clearing write
        for (int i = 0; i < DEPTH - 1; i++) begin
            cur[2] = ~cur[2];
            step(cur, 0, 0, A_NONE, 0);
        end
        cur[2] = ~cur[2];
        step(cur, 0, 1, A_PORT, 32'h0008_0001);
        chk_all("R5 overflow wins clear");

        finish_run();
    end
endmodule